// File: doc/BRIEF.md
# Translation Cache with Scoped Invalidation

This block is a small, fully associative translation cache for an I/O memory management unit. Each entry is keyed by a 16-bit address-space identifier together with a full 64-bit input address. It returns the translated output address, an address mask and a permission field. A lookup port answers combinationally from the valid bits and the per-entry compare results. A fill port is driven by the table walker after a successful walk. An invalidation port accepts one of three scopes: every entry, every entry of one identifier, or the single entry of one identifier and address.

New entries go to a round-robin victim slot, and the pointer advances on every fill. A fill whose key already sits in the cache rewrites that entry in place and does not create a second copy. An invalidation commits at the next clock edge, but it also masks the lookup in the same cycle, so a request issued alongside an invalidation never sees a stale translation. A synchronous reset empties the cache.

Top module: `xlt_cache`

## Requirements
- R1: A lookup hits only when a valid entry's identifier and its full input address both equal the request; if either field differs, the lookup misses.
- R2: On a hit, the output address, mask and permission equal the values stored by the fill that created or last rewrote the entry, in the same cycle as the request.
- R3: Invalidation opcode 1 (all) leaves no valid entry after the clock edge.
- R4: Invalidation opcode 2 (by identifier) removes every entry carrying that identifier, whatever its address, and leaves entries of other identifiers hitting.
- R5: Invalidation opcode 3 (by identifier and address) removes only the entry matching both fields; another entry with the same identifier keeps hitting. Opcode 0 does nothing.
- R6: While reset is high, and after it is released, every lookup misses until a new fill arrives.
- R7: A fill whose key matches a valid entry rewrites that entry, so one later invalidation by identifier and address makes the key miss.
- R8: A fill whose key is not present goes to a round-robin slot that advances by one on every fill, with the count wrapping at the depth (8). The ninth fill after a run of eight distinct fills evicts the first of them.
- R9: A lookup in the same cycle as an invalidation reports the state after the invalidation.
- R10: A fill becomes visible to lookups from the cycle after its clock edge. A fill in the same cycle as an invalidation survives that invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties the cache |
| lk_id | input | 16 | Lookup identifier |
| lk_va | input | 64 | Lookup input address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 64 | Translated output address on a hit |
| lk_mask | output | 64 | Address mask on a hit |
| lk_perm | output | 2 | Permission field on a hit |
| fill_en | input | 1 | Write a translation this cycle |
| fill_id | input | 16 | Fill identifier |
| fill_va | input | 64 | Fill input address |
| fill_pa | input | 64 | Fill output address |
| fill_mask | input | 64 | Fill address mask |
| fill_perm | input | 2 | Fill permission field |
| inv_op | input | 2 | Invalidation scope: 0 none, 1 all, 2 by identifier, 3 by identifier and address |
| inv_id | input | 16 | Invalidation identifier |
| inv_va | input | 64 | Invalidation input address |

## Verification
The hardest case to reach from the ports is eviction by the round-robin pointer. The pointer cannot be read, so the bench keeps its own count of every fill, including the fill that rewrites a duplicate key. It then does a run of eight distinct fills and a ninth, and checks that exactly the oldest of the eight now misses. Same-cycle interactions are the second hard area. The bench drives an invalidation together with a lookup, and a fill together with an invalidate-all, on one falling edge. It samples the combinational answer before the next rising edge and again after it.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int ID_W   = 16;
    localparam int VA_W   = 64;
    localparam int PA_W   = 64;
    localparam int PERM_W = 2;

    typedef enum logic [1:0] {
        INV_NONE  = 2'd0,
        INV_ALL   = 2'd1,
        INV_ID    = 2'd2,
        INV_ID_VA = 2'd3
    } inv_op_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   pa;
        logic [VA_W-1:0]   mask;
        logic [PERM_W-1:0] perm;
    } xlt_entry_t;

    function automatic logic key_eq(input xlt_entry_t e,
                                    input logic [ID_W-1:0] id,
                                    input logic [VA_W-1:0] va);
        return (e.id == id) && (e.va == va);
    endfunction

endpackage

// File: rtl/xlt_match.sv
module xlt_match
    import xlt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  xlt_entry_t        ents [DEPTH],
    input  logic [DEPTH-1:0]  valid,
    input  logic [ID_W-1:0]   q_id,
    input  logic [VA_W-1:0]   q_va,
    output logic [DEPTH-1:0]  id_vec,
    output logic [DEPTH-1:0]  key_vec
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign id_vec[g]  = valid[g] && (ents[g].id == q_id);
        assign key_vec[g] = valid[g] && key_eq(ents[g], q_id, q_va);
    end

endmodule

// File: rtl/xlt_sel.sv
module xlt_sel
    import xlt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xlt_entry_t        ents [DEPTH],
    input  logic [DEPTH-1:0]  sel,
    output logic              hit,
    output logic [PA_W-1:0]   pa,
    output logic [VA_W-1:0]   mask,
    output logic [PERM_W-1:0] perm
);

    always_comb begin
        pa   = '0;
        mask = '0;
        perm = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) begin
                pa   = pa   | ents[i].pa;
                mask = mask | ents[i].mask;
                perm = perm | ents[i].perm;
            end
        end
    end

    assign hit = |sel;

    // R7: fills never duplicate a key, so at most one way can match
    p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/xlt_store.sv
module xlt_store
    import xlt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  xlt_entry_t        fill_ent,
    input  logic [DEPTH-1:0]  fill_dup,
    input  logic [DEPTH-1:0]  kill,
    output xlt_entry_t        ents [DEPTH],
    output logic [DEPTH-1:0]  valid
);

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] slot;

    function automatic logic [PTR_W-1:0] oh_index(input logic [DEPTH-1:0] v);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (v[i]) r = r | PTR_W'(i);
        end
        return r;
    endfunction

    assign slot = (|fill_dup) ? oh_index(fill_dup) : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            ptr   <= '0;
        end else begin
            valid <= valid & ~kill;
            if (fill_en) begin
                valid[slot] <= 1'b1;
                ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) ents[slot] <= fill_ent;
    end

    p_reset_empty_r6: assert property (@(posedge clk)
        rst |=> (valid == '0));

    p_inv_all_r3: assert property (@(posedge clk) disable iff (rst)
        ((&kill) && !fill_en) |=> (valid == '0));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (ptr == (($past(ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));

    p_fill_valid_r10: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid != '0));

endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
    import xlt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   lk_id,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [VA_W-1:0]   lk_mask,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fill_en,
    input  logic [ID_W-1:0]   fill_id,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [VA_W-1:0]   fill_mask,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic [1:0]        inv_op,
    input  logic [ID_W-1:0]   inv_id,
    input  logic [VA_W-1:0]   inv_va
);

    xlt_entry_t       ents [DEPTH];
    xlt_entry_t       fill_ent;
    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] lk_idv, lk_key;
    logic [DEPTH-1:0] fl_idv, fl_key;
    logic [DEPTH-1:0] iv_idv, iv_key;
    logic [DEPTH-1:0] kill;
    logic [DEPTH-1:0] lk_sel;
    inv_op_e          op;

    assign op       = inv_op_e'(inv_op);
    assign fill_ent = '{id: fill_id, va: fill_va, pa: fill_pa,
                        mask: fill_mask, perm: fill_perm};

    xlt_match #(.DEPTH(DEPTH)) u_lk_match (
        .ents(ents), .valid(valid), .q_id(lk_id), .q_va(lk_va),
        .id_vec(lk_idv), .key_vec(lk_key));

    xlt_match #(.DEPTH(DEPTH)) u_fill_match (
        .ents(ents), .valid(valid), .q_id(fill_id), .q_va(fill_va),
        .id_vec(fl_idv), .key_vec(fl_key));

    xlt_match #(.DEPTH(DEPTH)) u_inv_match (
        .ents(ents), .valid(valid), .q_id(inv_id), .q_va(inv_va),
        .id_vec(iv_idv), .key_vec(iv_key));

    always_comb begin
        unique case (op)
            INV_ALL:   kill = '1;
            INV_ID:    kill = iv_idv;
            INV_ID_VA: kill = iv_key;
            default:   kill = '0;
        endcase
    end

    // lookups see the state after this cycle's invalidation
    assign lk_sel = lk_key & ~kill;

    xlt_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .fill_en(fill_en), .fill_ent(fill_ent),
        .fill_dup(fl_key), .kill(kill), .ents(ents), .valid(valid));

    xlt_sel #(.DEPTH(DEPTH)) u_sel (
        .clk(clk), .rst(rst), .ents(ents), .sel(lk_sel),
        .hit(lk_hit), .pa(lk_pa), .mask(lk_mask), .perm(lk_perm));

    p_lookup_after_inv_all_r9: assert property (@(posedge clk) disable iff (rst)
        (op == INV_ALL) |-> !lk_hit);

    p_lookup_after_inv_key_r5: assert property (@(posedge clk) disable iff (rst)
        (op == INV_ID_VA && inv_id == lk_id && inv_va == lk_va) |-> !lk_hit);

    p_fill_then_hit_r10: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_id == lk_id && fill_va == lk_va) |=>
            (($stable(lk_id) && $stable(lk_va) && inv_op == 2'd0) -> lk_hit));

    // unused id-only compare vectors of the lookup and fill instances
    logic unused_ok;
    assign unused_ok = ^{lk_idv, fl_idv};

endmodule

// File: tb/xlt_cache_tb.sv
`timescale 1ns/1ps
module xlt_cache_tb;
    import xlt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ID_W-1:0]   lk_id = '0;
    logic [VA_W-1:0]   lk_va = '0;
    logic              lk_hit;
    logic [PA_W-1:0]   lk_pa;
    logic [VA_W-1:0]   lk_mask;
    logic [PERM_W-1:0] lk_perm;
    logic              fill_en = 1'b0;
    logic [ID_W-1:0]   fill_id = '0;
    logic [VA_W-1:0]   fill_va = '0;
    logic [PA_W-1:0]   fill_pa = '0;
    logic [VA_W-1:0]   fill_mask = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic [1:0]        inv_op = 2'd0;
    logic [ID_W-1:0]   inv_id = '0;
    logic [VA_W-1:0]   inv_va = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xlt_cache u_dut (.*);

    typedef struct packed {
        logic              hit;
        logic [PA_W-1:0]   pa;
        logic [VA_W-1:0]   mask;
        logic [PERM_W-1:0] perm;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    event  chk_ev;

    // monitor: pop the expected item and compare with the live outputs
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(chk_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (lk_hit !== e.hit ||
                (e.hit && (lk_pa !== e.pa || lk_mask !== e.mask || lk_perm !== e.perm))) begin
                n_fail++;
                $display("FAIL %s: got hit=%0b pa=%h mask=%h perm=%0d, expected hit=%0b pa=%h mask=%h perm=%0d",
                         t, lk_hit, lk_pa, lk_mask, lk_perm, e.hit, e.pa, e.mask, e.perm);
            end
        end
    end

    // driver: set lookup inputs now, push expectation, sample 1 ns later
    task automatic probe(input logic [ID_W-1:0] id, input logic [VA_W-1:0] va,
                         input logic h, input logic [PA_W-1:0] pa,
                         input logic [VA_W-1:0] m, input logic [PERM_W-1:0] p,
                         input string tag);
        lk_id = id;
        lk_va = va;
        exp_q.push_back('{hit: h, pa: pa, mask: m, perm: p});
        tag_q.push_back(tag);
        #1 -> chk_ev;
        #0;
    endtask

    task automatic look(input logic [ID_W-1:0] id, input logic [VA_W-1:0] va,
                        input logic h, input logic [PA_W-1:0] pa,
                        input logic [VA_W-1:0] m, input logic [PERM_W-1:0] p,
                        input string tag);
        @(negedge clk);
        probe(id, va, h, pa, m, p, tag);
    endtask

    task automatic set_fill(input logic [ID_W-1:0] id, input logic [VA_W-1:0] va,
                            input logic [PA_W-1:0] pa, input logic [VA_W-1:0] m,
                            input logic [PERM_W-1:0] p);
        fill_en = 1'b1; fill_id = id; fill_va = va;
        fill_pa = pa; fill_mask = m; fill_perm = p;
    endtask

    task automatic do_fill(input logic [ID_W-1:0] id, input logic [VA_W-1:0] va,
                           input logic [PA_W-1:0] pa, input logic [VA_W-1:0] m,
                           input logic [PERM_W-1:0] p);
        @(negedge clk);
        set_fill(id, va, pa, m, p);
        @(posedge clk);
        #1 fill_en = 1'b0;
    endtask

    task automatic do_inv(input logic [1:0] op, input logic [ID_W-1:0] id,
                          input logic [VA_W-1:0] va);
        @(negedge clk);
        inv_op = op; inv_id = id; inv_va = va;
        @(posedge clk);
        #1 inv_op = 2'd0;
    endtask

    localparam logic [VA_W-1:0] M4K = 64'hFFF;

    initial begin
        repeat (3) @(posedge clk);
        // R6: miss while in reset
        look(16'h1, 64'h1000, 0, 0, 0, 0, "R6 in reset");
        @(negedge clk) rst = 1'b0;
        look(16'h1, 64'h1000, 0, 0, 0, 0, "R6 after reset");

        // fill 1: A
        do_fill(16'h1, 64'h1000, 64'hA000, M4K, 2'd3);
        look(16'h1, 64'h1000, 1, 64'hA000, M4K, 2'd3, "R2 hit data");
        look(16'h2, 64'h1000, 0, 0, 0, 0, "R1 id differs");
        look(16'h1, 64'h1001, 0, 0, 0, 0, "R1 address differs");
        look(16'h1, 64'h8000_0000_0000_1000, 0, 0, 0, 0, "R1 high address bit differs");

        // R10: fill not visible in its own cycle, visible next (fill 2: B)
        @(negedge clk);
        set_fill(16'h1, 64'h2000, 64'hB000, M4K, 2'd1);
        probe(16'h1, 64'h2000, 0, 0, 0, 0, "R10 same-cycle fill invisible");
        @(posedge clk); #1 fill_en = 1'b0;
        look(16'h1, 64'h2000, 1, 64'hB000, M4K, 2'd1, "R10 fill visible next cycle");

        // fill 3: C (other identifier, same address as A)
        do_fill(16'h2, 64'h1000, 64'hC000, M4K, 2'd2);

        // R9 + R4: invalidate id 1 with same-cycle lookup of A
        @(negedge clk);
        inv_op = 2'd2; inv_id = 16'h1;
        probe(16'h1, 64'h1000, 0, 0, 0, 0, "R9 same-cycle lookup sees inv");
        @(posedge clk); #1 inv_op = 2'd0;
        look(16'h1, 64'h2000, 0, 0, 0, 0, "R4 other address of id removed");
        look(16'h2, 64'h1000, 1, 64'hC000, M4K, 2'd2, "R4 other id kept");

        // R5: fills 4,5 (D,E); invalidate only D
        do_fill(16'h3, 64'h3000, 64'hD000, M4K, 2'd1);
        do_fill(16'h3, 64'h3008, 64'hE000, M4K, 2'd2);
        do_inv(2'd0, 16'h3, 64'h3000);
        look(16'h3, 64'h3000, 1, 64'hD000, M4K, 2'd1, "R5 opcode 0 no effect");
        do_inv(2'd3, 16'h3, 64'h3000);
        look(16'h3, 64'h3000, 0, 0, 0, 0, "R5 targeted entry removed");
        look(16'h3, 64'h3008, 1, 64'hE000, M4K, 2'd2, "R5 sibling kept");

        // R7: fill 6 rewrites E; a single targeted invalidate clears the key
        do_fill(16'h3, 64'h3008, 64'hE800, 64'hFFFF, 2'd0);
        look(16'h3, 64'h3008, 1, 64'hE800, 64'hFFFF, 2'd0, "R7 rewrite returns new data");
        do_inv(2'd3, 16'h3, 64'h3008);
        look(16'h3, 64'h3008, 0, 0, 0, 0, "R7 no second copy");

        // R3
        do_inv(2'd1, 16'h0, 64'h0);
        look(16'h2, 64'h1000, 0, 0, 0, 0, "R3 all removed");

        // R8: 6 fills so far; eight distinct fills land in all slots
        for (int k = 0; k < 8; k++)
            do_fill(16'h5, 64'(k * 16), 64'(32'hF000 + k), M4K, 2'd1);
        for (int k = 0; k < 8; k++)
            look(16'h5, 64'(k * 16), 1, 64'(32'hF000 + k), M4K, 2'd1, "R8 all eight resident");
        do_fill(16'h6, 64'h9000, 64'h9900, M4K, 2'd3);
        look(16'h5, 64'h0, 0, 0, 0, 0, "R8 oldest evicted");
        look(16'h5, 64'h10, 1, 64'hF001, M4K, 2'd1, "R8 second oldest kept");
        look(16'h6, 64'h9000, 1, 64'h9900, M4K, 2'd3, "R8 new entry hits");

        // R10: fill with invalidate-all in one cycle survives
        @(negedge clk);
        set_fill(16'h7, 64'h7000, 64'h7700, M4K, 2'd2);
        inv_op = 2'd1;
        @(posedge clk); #1 begin fill_en = 1'b0; inv_op = 2'd0; end
        look(16'h7, 64'h7000, 1, 64'h7700, M4K, 2'd2, "R10 fill survives inv all");
        look(16'h6, 64'h9000, 0, 0, 0, 0, "R3 older entry cleared");

        // R6: reset mid-run
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        look(16'h7, 64'h7000, 0, 0, 0, 0, "R6 reset empties");

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule